// File: doc/BRIEF.md
# Packed-Byte Absolute Difference and Average Unit

This execution unit sits in the media coprocessor of a 64-bit core. It treats each 64-bit operand as eight unsigned byte lanes. It performs three operations on them: a lane-wise absolute difference, a lane-wise average rounded half up, and a sum-of-absolute-differences step. The last of these adds each lane's difference into a private 24-bit accumulator for that lane. The first two return a 64-bit result with a write strobe. The accumulate form writes no destination and only advances the accumulator.

The unit decodes the instruction word itself and applies the checks that gate these operations. The coprocessor must be usable. The media enable bit of the status word must be set. The extension enable bit must be set. The format selector must name the byte format. When a check fails, exactly one exception line is raised, chosen by a fixed priority, and no result or accumulator state changes. The register file, the choice of vector or scalar second operand, and pipelining all belong to the surrounding core.

Top module: `pbsad_unit`

## Requirements
- R1: An instruction is recognised only when `issue_valid` is high and bits 31:26 equal 011110. Bits 5:0 must also be 001001 (absolute difference), 001000 (average) or 110101 (accumulate). Any other word produces no write, no exception and no accumulator change.
- R2: For absolute difference, byte lane i of `res_data` (bits 8i+7:8i) is |a_i − b_i| for unsigned bytes, and `res_we` is high in the same cycle.
- R3: For average, byte lane i of `res_data` is (a_i + b_i + 1) >> 1, formed without losing the carry, and `res_we` is high in the same cycle.
- R4: For accumulate, on the next clock edge lane i of `acc_q` (bits 24i+23:24i) gains the zero-extended |a_i − b_i|, wrapping modulo 2^24. `res_we` stays low.
- R5: If `cop_usable` is low, a recognised instruction raises `exc_cop_unusable` and no other exception.
- R6: Otherwise, if status bit 24 (media enable) is low, `exc_media_off` is raised.
- R7: Otherwise, if status bit 16 (extension enable) is low, `exc_reserved` is raised.
- R8: The format selector is bits 25:21, and only its low two bits are decoded. Values 00 and 10 are accepted. Values 01 and 11 raise `exc_reserved` when no higher check has fired.
- R9: At most one exception line is high at a time. Whenever any exception is high, `res_we` is low and the accumulator does not change.
- R10: A synchronous `rst` clears every accumulator lane to zero. The accumulator holds its value in every cycle without an accepted accumulate instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| opnd_a | input | 64 | First packed-byte operand |
| opnd_b | input | 64 | Second packed-byte operand |
| cop_usable | input | 1 | Coprocessor usable flag |
| status | input | 32 | Status word (bit 24 media enable, bit 16 extension enable) |
| res_data | output | 64 | Packed result, zero when not writing |
| res_we | output | 1 | Destination write enable |
| acc_q | output | 192 | Eight 24-bit accumulator lanes |
| exc_cop_unusable | output | 1 | Coprocessor unusable exception |
| exc_media_off | output | 1 | Media extension disabled exception |
| exc_reserved | output | 1 | Reserved instruction exception |

## Verification
The assertions assume that `issue_valid`, `insn`, the operands, `cop_usable` and `status` hold steady from the middle of one cycle to the clock edge that ends it. The accumulator and exception checks read their values at that edge. The stimulus changes every input only on the falling edge and holds it for one full cycle. Its random draws cover each enable on both sides, every format selector value, and opcodes and function codes outside the recognised set, so each assumption is met while every branch of the priority chain is reached.

// File: rtl/pbsad_pkg.sv
package pbsad_pkg;

   typedef enum logic [1:0] {
      OP_NONE    = 2'd0,
      OP_ABSDIFF = 2'd1,
      OP_AVG     = 2'd2,
      OP_ABSACC  = 2'd3
   } pbsad_op_e;

   localparam logic [5:0] MAJOR_OPC  = 6'b011110;
   localparam logic [5:0] FN_ABSDIFF = 6'b001001;
   localparam logic [5:0] FN_AVG     = 6'b001000;
   localparam logic [5:0] FN_ABSACC  = 6'b110101;

endpackage

// File: rtl/pbsad_decode.sv
module pbsad_decode
   import pbsad_pkg::*;
#(
   parameter int STATUS_W     = 32,
   parameter int MEDIA_EN_BIT = 24,
   parameter int EXT_EN_BIT   = 16
) (
   input  logic                issue_valid,
   input  logic [31:0]         insn,
   input  logic                cop_usable,
   input  logic [STATUS_W-1:0] status,
   output pbsad_op_e           op,
   output logic                exc_cu,
   output logic                exc_mx,
   output logic                exc_ri
);

   logic [5:0] opc_f;
   logic [4:0] fmt_f;
   logic [5:0] fn_f;
   pbsad_op_e  op_raw;
   logic       hit;
   logic       fmt_bad;
   logic       ext_off;
   logic       unused_fields;

   assign opc_f = insn[31:26];
   assign fmt_f = insn[25:21];
   assign fn_f  = insn[5:0];

   always_comb begin
      op_raw = OP_NONE;
      if (issue_valid && opc_f == MAJOR_OPC) begin
         case (fn_f)
            FN_ABSDIFF: op_raw = OP_ABSDIFF;
            FN_AVG:     op_raw = OP_AVG;
            FN_ABSACC:  op_raw = OP_ABSACC;
            default:    op_raw = OP_NONE;
         endcase
      end
   end

   assign hit     = (op_raw != OP_NONE);
   assign fmt_bad = fmt_f[0];
   assign ext_off = ~status[EXT_EN_BIT];

   // Priority chain: usable, media enable, then extension/format.
   assign exc_cu = hit && !cop_usable;
   assign exc_mx = hit && cop_usable && !status[MEDIA_EN_BIT];
   assign exc_ri = hit && cop_usable && status[MEDIA_EN_BIT] && (ext_off || fmt_bad);

   assign op = (exc_cu || exc_mx || exc_ri) ? OP_NONE : op_raw;

   assign unused_fields = ^{insn[20:6], fmt_f[4:1], status};

endmodule

// File: rtl/pbsad_lane.sv
module pbsad_lane #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   output logic [LANE_W-1:0] diff,
   output logic [LANE_W-1:0] avg
);

   localparam int SUM_W = LANE_W + 1;

   logic [SUM_W-1:0] sum_w;
   logic             a_ge_b;

   assign a_ge_b = (a >= b);
   assign diff   = a_ge_b ? (a - b) : (b - a);
   assign sum_w  = {1'b0, a} + {1'b0, b} + SUM_W'(1);
   assign avg    = sum_w[SUM_W-1:1];

endmodule

// File: rtl/pbsad_acc.sv
module pbsad_acc #(
   parameter int LANES  = 8,
   parameter int LANE_W = 8,
   parameter int ACC_W  = 24
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    acc_en,
   input  logic [LANES*LANE_W-1:0] diff_flat,
   output logic [LANES*ACC_W-1:0]  acc_q
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [ACC_W-1:0] acc_r;
      logic [ACC_W-1:0] incr;

      assign incr = ACC_W'(diff_flat[i*LANE_W +: LANE_W]);

      always_ff @(posedge clk) begin
         if (rst)
            acc_r <= '0;
         else if (acc_en)
            acc_r <= acc_r + incr;
      end

      assign acc_q[i*ACC_W +: ACC_W] = acc_r;
   end

   // R10: state held when no accepted accumulate
   assert_acc_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !acc_en |=> $stable(acc_q));

   // R10: first cycle out of reset sees cleared lanes
   assert_acc_cleared_R10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (acc_q == '0));

endmodule

// File: rtl/pbsad_unit.sv
module pbsad_unit
   import pbsad_pkg::*;
#(
   parameter int LANES        = 8,
   parameter int LANE_W       = 8,
   parameter int ACC_W        = 24,
   parameter int STATUS_W     = 32,
   parameter int MEDIA_EN_BIT = 24,
   parameter int EXT_EN_BIT   = 16,
   localparam int DATA_W      = LANES * LANE_W,
   localparam int ACC_FLAT_W  = LANES * ACC_W
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  issue_valid,
   input  logic [31:0]           insn,
   input  logic [DATA_W-1:0]     opnd_a,
   input  logic [DATA_W-1:0]     opnd_b,
   input  logic                  cop_usable,
   input  logic [STATUS_W-1:0]   status,
   output logic [DATA_W-1:0]     res_data,
   output logic                  res_we,
   output logic [ACC_FLAT_W-1:0] acc_q,
   output logic                  exc_cop_unusable,
   output logic                  exc_media_off,
   output logic                  exc_reserved
);

   if (ACC_W <= LANE_W) begin : g_chk_acc
      $error("pbsad_unit: ACC_W must exceed LANE_W");
   end
   if (DATA_W != 64) begin : g_chk_data
      $error("pbsad_unit: LANES*LANE_W must be 64");
   end
   if (MEDIA_EN_BIT >= STATUS_W || EXT_EN_BIT >= STATUS_W) begin : g_chk_bits
      $error("pbsad_unit: enable bit outside status word");
   end
   if (MEDIA_EN_BIT == EXT_EN_BIT) begin : g_chk_dup
      $error("pbsad_unit: enable bits must differ");
   end

   pbsad_op_e         op;
   logic [DATA_W-1:0] diff_flat;
   logic [DATA_W-1:0] avg_flat;
   logic              acc_en;

   pbsad_decode #(
      .STATUS_W     (STATUS_W),
      .MEDIA_EN_BIT (MEDIA_EN_BIT),
      .EXT_EN_BIT   (EXT_EN_BIT)
   ) u_dec (
      .issue_valid (issue_valid),
      .insn        (insn),
      .cop_usable  (cop_usable),
      .status      (status),
      .op          (op),
      .exc_cu      (exc_cop_unusable),
      .exc_mx      (exc_media_off),
      .exc_ri      (exc_reserved)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] la, lb, lo, hi;
      assign la = opnd_a[i*LANE_W +: LANE_W];
      assign lb = opnd_b[i*LANE_W +: LANE_W];

      pbsad_lane #(.LANE_W(LANE_W)) u_lane (
         .a    (la),
         .b    (lb),
         .diff (diff_flat[i*LANE_W +: LANE_W]),
         .avg  (avg_flat[i*LANE_W +: LANE_W])
      );

      assign lo = (la < lb) ? la : lb;
      assign hi = (la < lb) ? lb : la;

      // R2: difference spans exactly from the smaller to the larger byte
      assert_diff_span_R2: assert property (@(posedge clk) disable iff (rst)
         (LANE_W'(lo + diff_flat[i*LANE_W +: LANE_W]) == hi));

      // R3: average never leaves the operand interval
      assert_avg_bounded_R3: assert property (@(posedge clk) disable iff (rst)
         (avg_flat[i*LANE_W +: LANE_W] >= lo) && (avg_flat[i*LANE_W +: LANE_W] <= hi));
   end

   always_comb begin
      case (op)
         OP_ABSDIFF: res_data = diff_flat;
         OP_AVG:     res_data = avg_flat;
         default:    res_data = '0;
      endcase
   end

   assign res_we = (op == OP_ABSDIFF) || (op == OP_AVG);
   assign acc_en = (op == OP_ABSACC);

   pbsad_acc #(
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .ACC_W  (ACC_W)
   ) u_acc (
      .clk       (clk),
      .rst       (rst),
      .acc_en    (acc_en),
      .diff_flat (diff_flat),
      .acc_q     (acc_q)
   );

   // R9: only one exception line at a time
   assert_single_exc_R9: assert property (@(posedge clk) disable iff (rst)
      $onehot0({exc_cop_unusable, exc_media_off, exc_reserved}));

   // R9: an excepting instruction never writes
   assert_no_write_on_exc_R9: assert property (@(posedge clk) disable iff (rst)
      (exc_cop_unusable || exc_media_off || exc_reserved) |-> !res_we);

   // R5: lower exceptions only when the coprocessor is usable
   assert_cu_first_R5: assert property (@(posedge clk) disable iff (rst)
      (exc_media_off || exc_reserved) |-> cop_usable);

   // R6: reserved exception only once media enable is set
   assert_media_before_ri_R6: assert property (@(posedge clk) disable iff (rst)
      exc_reserved |-> status[MEDIA_EN_BIT]);

   // R4: the accumulate form writes no destination
   assert_acc_no_write_R4: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && insn[5:0] == FN_ABSACC) |-> !res_we);

endmodule

// File: tb/sim_pbsad_unit.sv
module sim_pbsad_unit;

   localparam int LANES = 8;
   localparam int LW    = 8;
   localparam int AW    = 24;
   localparam logic [5:0] OPC   = 6'b011110;
   localparam logic [5:0] F_DIF = 6'b001001;
   localparam logic [5:0] F_AVG = 6'b001000;
   localparam logic [5:0] F_ACC = 6'b110101;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst = 1'b1;
   logic          issue_valid = 1'b0;
   logic [31:0]   insn = '0;
   logic [63:0]   opnd_a = '0;
   logic [63:0]   opnd_b = '0;
   logic          cop_usable = 1'b0;
   logic [31:0]   status = '0;
   logic [63:0]   res_data;
   logic          res_we;
   logic [191:0]  acc_q;
   logic          exc_cop_unusable, exc_media_off, exc_reserved;

   pbsad_unit u0 (
      .clk (clk), .rst (rst), .issue_valid (issue_valid), .insn (insn),
      .opnd_a (opnd_a), .opnd_b (opnd_b), .cop_usable (cop_usable),
      .status (status), .res_data (res_data), .res_we (res_we),
      .acc_q (acc_q), .exc_cop_unusable (exc_cop_unusable),
      .exc_media_off (exc_media_off), .exc_reserved (exc_reserved)
   );

   int n_run  = 0;
   int n_fail = 0;
   logic [AW-1:0] m_acc [LANES];

   function automatic logic [63:0] lanes_op(logic [63:0] x, logic [63:0] y, bit do_avg);
      logic [63:0] r;
      r = '0;
      for (int i = 0; i < LANES; i++) begin
         logic [7:0] xa, yb;
         logic [8:0] s;
         xa = x[i*8 +: 8];
         yb = y[i*8 +: 8];
         s  = {1'b0, xa} + {1'b0, yb} + 9'd1;
         if (do_avg) r[i*8 +: 8] = s[8:1];
         else        r[i*8 +: 8] = (xa >= yb) ? xa - yb : yb - xa;
      end
      return r;
   endfunction

   function automatic logic [191:0] model_flat();
      logic [191:0] f;
      for (int i = 0; i < LANES; i++) f[i*AW +: AW] = m_acc[i];
      return f;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [191:0] act, logic [191:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(bit v, logic [5:0] opc, logic [4:0] fmt, logic [5:0] fn,
                        logic [63:0] x, logic [63:0] y, bit cu, logic [31:0] st, bit do_chk);
      bit hit, e_cu, e_mx, e_ri, ok, we;
      logic [63:0] exp_d;
      string tag;
      logic [191:0] act_o, exp_o;
      @(negedge clk);
      issue_valid = v;
      insn        = {opc, fmt, 15'($urandom), fn};
      opnd_a      = x;
      opnd_b      = y;
      cop_usable  = cu;
      status      = st;
      #2;
      hit  = v && (opc == OPC) && (fn == F_DIF || fn == F_AVG || fn == F_ACC);
      e_cu = hit && !cu;
      e_mx = hit && cu && !st[24];
      e_ri = hit && cu && st[24] && (!st[16] || fmt[0]);
      ok   = hit && !(e_cu || e_mx || e_ri);
      we   = ok && (fn != F_ACC);
      exp_d = !we ? 64'h0 : lanes_op(x, y, fn == F_AVG);
      if (!hit)            tag = "R1";
      else if (e_cu)       tag = "R5/R9";
      else if (e_mx)       tag = "R6/R9";
      else if (!st[16])    tag = "R7/R9";
      else if (fmt[0])     tag = "R8/R9";
      else if (fn == F_DIF) tag = "R2";
      else if (fn == F_AVG) tag = "R3";
      else                 tag = "R4";
      act_o = {124'h0, exc_cop_unusable, exc_media_off, exc_reserved, res_we, res_data};
      exp_o = {124'h0, e_cu, e_mx, e_ri, we, exp_d};
      if (do_chk) chk(act_o == exp_o, tag, "exc/we/data", act_o, exp_o);
      @(posedge clk);
      #1;
      if (ok && fn == F_ACC)
         for (int i = 0; i < LANES; i++) m_acc[i] = m_acc[i] + AW'(lanes_op(x, y, 1'b0)[i*8 +: 8]);
      if (do_chk) chk(acc_q == model_flat(), (ok && fn == F_ACC) ? "R4" : "R10",
                      "accumulator", acc_q, model_flat());
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      issue_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < LANES; i++) m_acc[i] = '0;
      #1;
      chk(acc_q == '0, "R10", "reset clear", acc_q, '0);
   endtask

   localparam logic [31:0] ST_OK = 32'h0101_0000;

   initial begin
      void'($urandom(32'd2468));
      for (int i = 0; i < LANES; i++) m_acc[i] = '0;
      repeat (3) @(posedge clk);
      do_reset();
      #1;
      chk({res_we, exc_cop_unusable, exc_media_off, exc_reserved} == 4'b0, "R1",
          "idle outputs", {188'h0, res_we, exc_cop_unusable, exc_media_off, exc_reserved}, '0);

      // Directed: main functions and edge values
      issue(1, OPC, 5'b00000, F_DIF, 64'h00FF_7F80_0102_FE00, 64'hFF00_807F_0201_00FE, 1, ST_OK, 1);
      issue(1, OPC, 5'b00000, F_AVG, 64'hFFFF_0000_FF01_7F80, 64'hFFFF_0100_0001_8080, 1, ST_OK, 1);
      issue(1, OPC, 5'b00010, F_DIF, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1, ST_OK, 1);
      issue(1, OPC, 5'b11100, F_AVG, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 1, ST_OK, 1);
      issue(1, OPC, 5'b00000, F_ACC, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, ST_OK, 1);
      issue(1, OPC, 5'b00010, F_ACC, 64'h0010_2030_4050_6070, 64'h7060_5040_3020_1000, 1, ST_OK, 1);
      // Exceptions and priority
      issue(1, OPC, 5'b00001, F_ACC, 64'hFF, 64'h0, 0, 32'h0, 1);
      issue(1, OPC, 5'b00001, F_DIF, 64'hFF, 64'h0, 1, 32'h0001_0000, 1);
      issue(1, OPC, 5'b00001, F_AVG, 64'hFF, 64'h0, 1, 32'h0100_0000, 1);
      issue(1, OPC, 5'b00001, F_ACC, 64'hFF, 64'h0, 1, ST_OK, 1);
      issue(1, OPC, 5'b00011, F_DIF, 64'hFF, 64'h0, 1, ST_OK, 1);
      // Not recognised
      issue(1, 6'b011111, 5'b00000, F_ACC, 64'hFF, 64'h0, 1, ST_OK, 1);
      issue(1, OPC, 5'b00000, 6'b001010, 64'hFF, 64'h0, 1, ST_OK, 1);
      issue(0, OPC, 5'b00000, F_ACC, 64'hFF, 64'h0, 1, ST_OK, 1);

      // Constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [5:0] opc, fn;
         logic [31:0] st;
         int pick;
         opc  = ($urandom_range(0, 9) != 0) ? OPC : 6'($urandom);
         pick = $urandom_range(0, 9);
         fn   = (pick < 3) ? F_DIF : (pick < 6) ? F_AVG : (pick < 9) ? F_ACC : 6'($urandom);
         st   = $urandom;
         st[24] = ($urandom_range(0, 9) != 0);
         st[16] = ($urandom_range(0, 9) != 0);
         issue($urandom_range(0, 9) != 0, opc, 5'($urandom), fn,
               {$urandom, $urandom}, {$urandom, $urandom},
               $urandom_range(0, 9) != 0, st, 1);
      end

      // Reset in mid-run
      do_reset();

      // Wrap: 65800 * 255 mod 2^24 = 1784 per lane
      for (int n = 0; n < 65800; n++)
         issue(1, OPC, 5'b00000, F_ACC, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, ST_OK, n == 65799);
      chk(acc_q[23:0] == 24'd1784, "R4", "wrap lane 0", {168'h0, acc_q[23:0]}, 192'd1784);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule